// File: doc/BRIEF.md
# Stereo Volume Stage with Raised-Cosine Soft Mute

This block scales a stereo stream of signed 24-bit samples by a gain built from two factors: a decibel attenuation selected by a 6-bit volume code, and a soft-mute factor that moves along a raised-cosine curve instead of cutting the signal at once. One gain is shared by the left and right channels. Each sample pair that arrives with `in_valid` high produces one scaled pair with `out_valid` high one clock later.

The soft-mute factor is taken from a position that runs from 0 (full level) to 32 (silence). The position moves one step toward the requested end after every 32 accepted samples, so a complete fade takes 1024 sample periods. Releasing or re-asserting the request part way through reverses the walk from wherever the position stands. The block leaves reset fully muted and only fades in once the mute request is driven low. A status output reports whether a mute is requested or still in effect.

Top module: `soft_mute_volume`

## Requirements
- R1: Volume codes 0 and 1 both give unity gain (Q2.14 value 16384); with the mute position at 0 an accepted sample leaves the block unchanged.
- R2: A volume code c from 2 to 53 gives (c-1) dB of attenuation; its gain is round(16384 * 10^(-(c-1)/20)).
- R3: Codes 54 to 56 give 54 dB, codes 57 to 59 give 57 dB, codes 60 to 62 give 60 dB of attenuation, and code 63 gives a gain of 0, so every output sample is 0.
- R4: Left and right are scaled by the same gain in the same cycle.
- R5: With volume gain v and mute factor m, the applied gain is g = floor((v*m + 8192) / 16384) and the output is floor((s*g + 8192) / 16384) clamped to the signed 24-bit range; `out_valid` and the outputs follow an accepted sample at the next rising edge, and the outputs hold otherwise.
- R6: The mute factor at position p (0..32) is round(16384 * (1 + cos(pi*p/32)) / 2); each accepted sample advances a dwell count, and when 32 samples have been counted at one position the position moves by one toward 32 while `mute_req` is 1, or toward 0 while it is 0; it stops at the end it is heading for.
- R7: In any cycle where `mute_req` differs from its value in the previous cycle, the dwell count restarts at zero and the position is kept, so a reversed fade starts from the current position.
- R8: `muting` is 1 when the previous cycle's `mute_req` was 1 or the position is not 0, and 0 otherwise.
- R9: Synchronous active-low reset sets the position to 32, the dwell count to 0, the stored request to 1, `out_valid` to 0 and both outputs to 0, so `muting` reads 1.
- R10: Cycles with `in_valid` low produce no output and neither advance the dwell count nor move the position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A sample pair is present on the inputs |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| vol_code | input | 6 | Attenuation code for both channels |
| mute_req | input | 1 | 1 fades toward silence, 0 fades toward full level |
| out_valid | output | 1 | A scaled pair is present on the outputs |
| out_left | output | 24 | Scaled left sample, signed |
| out_right | output | 24 | Scaled right sample, signed |
| muting | output | 1 | Mute requested or still in effect |

## Verification
The bench follows a complete fade-in from the reset state with idle cycles scattered among the samples. A design that counted idle cycles would reach full level too early, and one that stepped on the wrong dwell count would pick the wrong curve point; either way the scaled samples would stop matching. It sweeps the volume codes at the seams of the mapping (0 and 1, 53 and 54, each coarse group and 63) with full-scale positive and negative samples, which exposes an off-by-one dB table, a rounding error or a missing clamp. A fade is also reversed part way through, so a design that jumped to an end point or kept a stale dwell count would produce wrong levels on the way back, and the status bit is compared on every cycle against the expected position and stored request.

// File: rtl/vsm_pkg.sv
// Shared widths and the compile-time gain functions for the soft-mute volume stage.
// Assumes gains are unsigned Q2.14 values no greater than 1.0.
package vsm_pkg;
    localparam int SAMPLE_W = 24;
    localparam int FRAC_W   = 14;
    localparam int GAIN_W   = FRAC_W + 1;
    localparam int CODE_W   = 6;

    // Attenuation in dB for a volume code; -1 stands for full silence.
    function automatic int code_atten_db(input int code);
        if (code <= 1)  return 0;
        if (code <= 53) return code - 1;
        if (code <= 56) return 54;
        if (code <= 59) return 57;
        if (code <= 62) return 60;
        return -1;
    endfunction

    // Linear Q2.14 gain for an attenuation in dB, rounded to nearest.
    function automatic logic [GAIN_W-1:0] db_gain(input int db);
        real lin;
        if (db < 0) return '0;
        lin = (2.0 ** FRAC_W) * (10.0 ** (-db / 20.0));
        return GAIN_W'($rtoi(lin + 0.5));
    endfunction

    // Raised-cosine Q2.14 factor for ramp position pos out of steps.
    function automatic logic [GAIN_W-1:0] cos_gain_at(input int pos, input int steps);
        real lin;
        lin = (2.0 ** FRAC_W) * (1.0 + $cos(3.14159265358979 * pos / steps)) / 2.0;
        return GAIN_W'($rtoi(lin + 0.5));
    endfunction
endpackage

// File: rtl/vsm_vol_lut.sv
// Volume lookup: maps the attenuation code to a Q2.14 linear gain.
// The table is filled at elaboration from the package functions; no clock.
module vsm_vol_lut
    import vsm_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);
    localparam int N_CODES = 1 << CODE_W;

    logic [GAIN_W-1:0] lut [N_CODES];

    // One constant entry per code.
    for (genvar i = 0; i < N_CODES; i++) begin : g_entry
        localparam logic [GAIN_W-1:0] ENTRY = db_gain(code_atten_db(i));
        assign lut[i] = ENTRY;
    end

    // Select the entry for the current code.
    assign gain = lut[code];
endmodule

// File: rtl/vsm_ramp_ctrl.sv
// Soft-mute ramp: walks a position between 0 (full) and STEPS (silent),
// one step per DWELL accepted samples, and looks up the raised-cosine factor.
// Assumes mute_req is synchronous to clk.
module vsm_ramp_ctrl
    import vsm_pkg::*;
#(
    parameter int STEPS = 32,
    parameter int DWELL = 32,
    parameter int POS_W = $clog2(STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              mute_req,
    output logic [POS_W-1:0]  pos,
    output logic [GAIN_W-1:0] cos_gain,
    output logic              muting
);
    localparam int SUB_W = (DWELL > 1) ? $clog2(DWELL) : 1;
    localparam logic [POS_W-1:0] POS_MAX  = POS_W'(STEPS);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(DWELL - 1);

    logic [SUB_W-1:0]  dwell_q;
    logic              req_q;
    logic              toggled;
    logic              moving;
    logic [GAIN_W-1:0] curve [STEPS + 1];

    // Curve points computed at elaboration.
    for (genvar p = 0; p <= STEPS; p++) begin : g_curve
        localparam logic [GAIN_W-1:0] POINT = cos_gain_at(p, STEPS);
        assign curve[p] = POINT;
    end

    // Request change and whether the position still has room to move.
    assign toggled = (mute_req != req_q);
    assign moving  = mute_req ? (pos != POS_MAX) : (pos != '0);

    // Position, dwell count and stored request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos     <= POS_MAX;
            dwell_q <= '0;
            req_q   <= 1'b1;
        end else begin
            req_q <= mute_req;
            if (toggled || !moving) begin
                dwell_q <= '0;
            end else if (sample_en) begin
                if (dwell_q == SUB_LAST) begin
                    dwell_q <= '0;
                    pos     <= mute_req ? pos + 1'b1 : pos - 1'b1;
                end else begin
                    dwell_q <= dwell_q + 1'b1;
                end
            end
        end
    end

    // Factor for the current position and the status flag.
    assign cos_gain = curve[pos];
    assign muting   = req_q | (pos != '0);

    p_pos_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_MAX);
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> $stable(pos));
    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> (pos == $past(pos)) || (pos == $past(pos) + 1'b1) || (pos + 1'b1 == $past(pos)));
    p_hold_on_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_req != req_q) |=> $stable(pos));
endmodule

// File: rtl/vsm_chan_scale.sv
// One channel multiplier: signed sample times unsigned Q2.14 gain,
// round half up, clamp to the sample width, register on en.
module vsm_chan_scale
    import vsm_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic [GAIN_W-1:0]          gain,
    output logic signed [SAMPLE_W-1:0] dout
);
    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;
    localparam int SHR_W  = PROD_W - FRAC_W;
    localparam logic signed [PROD_W-1:0] HALF   = PROD_W'(1 << (FRAC_W - 1));
    localparam logic signed [SHR_W-1:0]  SAT_HI = SHR_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [SHR_W-1:0]  SAT_LO = ~SAT_HI;

    logic signed [PROD_W-1:0]   prod;
    logic signed [SHR_W-1:0]    shr;
    logic signed [SAMPLE_W-1:0] sat;

    // Multiply, round and clamp.
    always_comb begin
        prod = PROD_W'(din) * PROD_W'($signed({1'b0, gain}));
        shr  = SHR_W'((prod + HALF) >>> FRAC_W);
        if (shr > SAT_HI)      sat = SAT_HI[SAMPLE_W-1:0];
        else if (shr < SAT_LO) sat = SAT_LO[SAMPLE_W-1:0];
        else                   sat = shr[SAMPLE_W-1:0];
    end

    // Output register, updated only for accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n)  dout <= '0;
        else if (en) dout <= sat;
    end

    p_zero_gain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en && (gain == '0) |=> dout == '0);
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(dout));
endmodule

// File: rtl/soft_mute_volume.sv
// Stereo volume and raised-cosine soft-mute stage. Combines the dB gain and
// the ramp factor into one gain and applies it to both channels with a
// single register of latency. Assumes all inputs are synchronous to clk.
module soft_mute_volume
    import vsm_pkg::*;
#(
    parameter int RAMP_STEPS = 32,
    parameter int RAMP_DWELL = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]          vol_code,
    input  logic                       mute_req,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic                       muting
);
    localparam int POS_W   = $clog2(RAMP_STEPS + 1);
    localparam int GPROD_W = 2 * GAIN_W + 1;
    localparam int N_CH    = 2;

    logic [GAIN_W-1:0]          vol_gain;
    logic [GAIN_W-1:0]          cos_gain;
    logic [GAIN_W-1:0]          total_gain;
    logic [GPROD_W-1:0]         gain_prod;
    logic [POS_W-1:0]           ramp_pos;
    logic signed [SAMPLE_W-1:0] ch_in  [N_CH];
    logic signed [SAMPLE_W-1:0] ch_out [N_CH];

    vsm_vol_lut u_vol_lut (
        .code (vol_code),
        .gain (vol_gain)
    );

    vsm_ramp_ctrl #(
        .STEPS (RAMP_STEPS),
        .DWELL (RAMP_DWELL),
        .POS_W (POS_W)
    ) u_ramp (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (in_valid),
        .mute_req  (mute_req),
        .pos       (ramp_pos),
        .cos_gain  (cos_gain),
        .muting    (muting)
    );

    // Product of volume gain and ramp factor, rounded back to Q2.14.
    assign gain_prod  = GPROD_W'(vol_gain) * GPROD_W'(cos_gain) + GPROD_W'(1 << (FRAC_W - 1));
    assign total_gain = GAIN_W'(gain_prod >> FRAC_W);

    assign ch_in[0] = in_left;
    assign ch_in[1] = in_right;

    // Identical multiplier per channel, sharing one gain.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        vsm_chan_scale u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (in_valid),
            .din   (ch_in[c]),
            .gain  (total_gain),
            .dout  (ch_out[c])
        );
    end

    assign out_left  = ch_out[0];
    assign out_right = ch_out[1];

    // Output strobe follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    p_unity_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (ramp_pos == '0) && (vol_code <= CODE_W'(1))
        |=> (out_left == $past(in_left)) && (out_right == $past(in_right)));
    p_silence_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (ramp_pos == POS_W'(RAMP_STEPS)) |=> (out_left == '0) && (out_right == '0));
    p_equal_channels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && (in_left == in_right) |=> out_left == out_right);
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
endmodule

// File: tb/soft_mute_volume_bench.sv
// Scoreboard bench: drive task predicts each scaled pair from the
// requirements and queues it; a monitor compares pairs as they appear.
module soft_mute_volume_bench;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [23:0] in_left = '0;
    logic signed [23:0] in_right = '0;
    logic [5:0]         vol_code = '0;
    logic               mute_req = 1'b1;
    logic               out_valid;
    logic signed [23:0] out_left;
    logic signed [23:0] out_right;
    logic               muting;

    typedef struct {
        logic signed [23:0] l;
        logic signed [23:0] r;
        string              tag;
    } item_t;

    item_t  sb_q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     done  = 1'b0;
    longint vg [64];
    longint cg [33];
    int     m_pos = 32;
    int     m_dw  = 0;
    bit     m_req = 1'b1;

    always #2 clk = ~clk;

    soft_mute_volume u_soft_mute_volume (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
        .in_left (in_left), .in_right (in_right), .vol_code (vol_code),
        .mute_req (mute_req), .out_valid (out_valid),
        .out_left (out_left), .out_right (out_right), .muting (muting)
    );

    function automatic int atten(input int c);
        if (c < 2)   return 0;
        if (c < 54)  return c - 1;
        if (c < 57)  return 54;
        if (c < 60)  return 57;
        if (c < 63)  return 60;
        return -1;
    endfunction

    function automatic logic signed [23:0] scl(input int s, input longint g);
        longint p;
        p = (longint'(s) * g + 8192) >>> 14;
        if (p > 8388607)  p = 8388607;
        if (p < -8388608) p = -8388608;
        return p[23:0];
    endfunction

    function automatic int pat(input int i, input int k);
        case (i % 5)
            0:       return 8388607;
            1:       return -8388608;
            default: return ((i * 1103515 + k * 7919) % 16777216) - 8388608;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // One cycle of stimulus; predicts output and updates the ramp model.
    task automatic drive(input bit v, input int l, input int r, input int code,
                         input bit mreq, input string tag);
        longint g;
        item_t  it;
        @(negedge clk);
        in_valid = v;
        in_left  = 24'(l);
        in_right = 24'(r);
        vol_code = 6'(code);
        mute_req = mreq;
        if (v) begin
            g = (vg[code] * cg[m_pos] + 8192) >>> 14;
            it.l = scl(l, g);
            it.r = scl(r, g);
            it.tag = tag;
            sb_q.push_back(it);
        end
        if (mreq != m_req)                   m_dw = 0;   // R7 restart on toggle
        else if (mreq ? m_pos == 32 : m_pos == 0) m_dw = 0;
        else if (v) begin                                // R10 idle cycles hold
            if (m_dw == 31) begin
                m_dw = 0;
                m_pos += mreq ? 1 : -1;
            end else begin
                m_dw++;
            end
        end
        m_req = mreq;
        @(posedge clk);
        #1;
        check(muting == (m_req || m_pos != 0), "R8 muting", longint'(muting),
              longint'(m_req || m_pos != 0));
    endtask

    // Monitor: compare every produced pair against the queue head.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R5 unexpected output", 1, 0);
                end else begin
                    it = sb_q.pop_front();
                    check(out_left == it.l, {it.tag, " left"}, out_left, it.l);
                    check(out_right == it.r, {it.tag, " right"}, out_right, it.r);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R5 watchdog actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int codes [12] = '{0, 1, 2, 20, 53, 54, 56, 57, 59, 60, 62, 63};
        for (int c = 0; c < 64; c++)
            vg[c] = (atten(c) < 0) ? 0 : longint'($rtoi(16384.0 * (10.0 ** (-atten(c) / 20.0)) + 0.5));
        for (int p = 0; p <= 32; p++)
            cg[p] = longint'($rtoi(16384.0 * (1.0 + $cos(3.14159265358979 * p / 32.0)) / 2.0 + 0.5));

        // R9: reset state.
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
        check(muting == 1'b1, "R9 muting", muting, 1);
        check(out_left == 0 && out_right == 0, "R9 outputs", out_left, 0);
        rst_n = 1'b1;

        // R6: held mute at the floor gives silence.
        for (int i = 0; i < 12; i++) drive(1'b1, pat(i, 1), pat(i, 2), 0, 1'b1, "R6 floor");

        // R6 R10: fade in with idle cycles mixed in.
        for (int i = 0; i < 1250; i++)
            drive((i % 7) != 3, pat(i, 3), pat(i, 4), 0, 1'b0, "R6 R10 fade-in");

        // R1 R2 R3 R4: volume mapping at full level.
        foreach (codes[j]) begin
            string t;
            t = (codes[j] < 2) ? "R1" : (codes[j] < 54) ? "R2" : "R3";
            drive(1'b1, 8388607, -8388608, codes[j], 1'b0, t);
            drive(1'b1, -8388608, 8388607, codes[j], 1'b0, t);
            drive(1'b1, pat(j + 2, 5), pat(j + 2, 5), codes[j], 1'b0, "R4 same gain");
            drive(1'b1, pat(j + 3, 6), pat(j + 4, 7), codes[j], 1'b0, t);
            drive(1'b0, 0, 0, codes[j], 1'b0, "R10 idle");
        end

        // R7: partial fade out, reversed part way, then back to full.
        for (int i = 0; i < 300; i++) drive(1'b1, pat(i, 8), pat(i, 9), 2, 1'b1, "R7 fade-out");
        for (int i = 0; i < 420; i++) drive(1'b1, pat(i, 10), pat(i, 11), 2, 1'b0, "R7 reversed");
        drive(1'b1, 1234567, -7654321, 0, 1'b0, "R1 after return");

        repeat (3) drive(1'b0, 0, 0, 0, 1'b0, "R10 drain");
        check(sb_q.size() == 0, "R5 missing outputs", sb_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule